// File: doc/BRIEF.md
# Vector Packet Input Reader

This block pulls vector packets out of an input FIFO, one 64-bit word per handshake, and routes each payload to one of several processing clusters. A packet is a header word, a payload of 32-bit elements packed two to a word, and one trailing sync word. The reader decodes the header and presents its fields to the main controller. It then waits for a grant that names the target cluster and streams the payload to that cluster with a one-hot select and a beat counter.

A length counter finds the end of the payload, so the reader knows which word must be the sync word. If that word does not match the sync constant, the reader flags a sync error. It then throws words away until the stream lines up again. A header whose length is out of range is treated the same way. The main controller uses the header bits to pick a cluster, and the error pulses to keep statistics.

Top module: `vec_pkt_reader`

## Requirements
- R1: `in_req` is high only while the FIFO is not empty (`in_empty` low) and the reader is in a reading phase. A word is consumed in any cycle where `in_req` and `in_ack` are both high.
- R2: The header word is decoded as follows: bits 31:0 vector ID, bits 47:32 length in 32-bit elements, bits 55:48 target number, bits 59:56 version, bit 60 software/hardware control flag, bit 61 data/command type. Bits 63:62 are ignored.
- R3: After a legal header, `hdr_valid` stays high with stable header outputs until `grant` is sampled high, and no FIFO word is read while it waits. `grant_cluster` is captured in the cycle `grant` is sampled.
- R4: A header length of 0 or above `MAX_LEN` produces a one-cycle `len_err` pulse and no `hdr_valid`. The reader then enters the discard phase.
- R5: The payload is written as ceil(length/2) beats, with the earlier element in bits 31:0. Each beat drives `wr_en` and sets the `wr_cs` bit of the granted cluster (one-hot). `wr_cnt` gives the beat index, counting from 0.
- R6: `wr_last` marks the final beat. For an odd length, bits 63:32 of that beat are forced to zero whatever the FIFO supplied.
- R7: If the word after the payload equals `SYNC_WORD`, `pkt_done` pulses for one cycle, one clock after that word is consumed. The next word is read as a header.
- R8: If the word after the payload differs from `SYNC_WORD`, `sync_err` pulses for one cycle instead. Words are then discarded with no write until a word equal to `SYNC_WORD` is consumed, and the word after it is read as a header.
- R9: When `in_ack` is held low or the FIFO runs empty partway through a packet, no beat is repeated, lost or reordered.
- R10: After reset, `in_req`, `hdr_valid`, `wr_en`, `wr_cs`, `pkt_done`, `sync_err` and `len_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 64 | FIFO head word |
| in_empty | input | 1 | FIFO empty flag |
| in_ack | input | 1 | FIFO acknowledge; a word moves when high together with in_req |
| in_req | output | 1 | Read request to the FIFO |
| hdr_valid | output | 1 | Header fields valid, waiting for grant |
| hdr_type | output | 1 | Data/command type bit |
| hdr_ctl | output | 1 | Software/hardware control flag |
| hdr_ver | output | 4 | Version field |
| hdr_target | output | 8 | Target processor number |
| hdr_len | output | 16 | Payload length in 32-bit elements |
| hdr_vid | output | 32 | Vector ID or command field |
| grant | input | 1 | Main controller grant |
| grant_cluster | input | $clog2(NCL) | Cluster chosen by the main controller |
| wr_en | output | 1 | Payload beat write strobe |
| wr_cs | output | NCL | One-hot cluster select |
| wr_data | output | 64 | Payload beat, two elements |
| wr_cnt | output | $clog2(MAX_LEN/2) | Beat index inside the packet |
| wr_last | output | 1 | Final payload beat |
| pkt_done | output | 1 | Packet ended with a good sync word |
| sync_err | output | 1 | Sync word mismatch |
| len_err | output | 1 | Illegal header length |

## Verification
The last-beat write, with its padding, and the flow control from the FIFO can act in the same cycle. The beat counter must roll over exactly once even when `in_ack` drops or the FIFO goes empty around that beat. The bench gates `in_ack` in a repeating pattern for most of the run and feeds packets one at a time, so the FIFO drains between them. It fills the upper half of each padded last word with junk. The scoreboard compares every write against a queue of expected beats, checking data, select, index and last flag. Any extra, missing or duplicated beat therefore shows up as a mismatch or a leftover item.

// File: rtl/vpr_pkg.sv
package vpr_pkg;

    // Header fields below the two ignored top bits of the 64-bit word.
    typedef struct packed {
        logic        is_cmd;
        logic        sw_ctl;
        logic [3:0]  ver;
        logic [7:0]  target;
        logic [15:0] len;
        logic [31:0] vid;
    } vpr_hdr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_GRANT,
        ST_PAY,
        ST_TAIL,
        ST_DISC
    } vpr_state_t;

    // Number of 64-bit beats needed for len 32-bit elements.
    function automatic logic [15:0] beats_of(input logic [15:0] len);
        logic [16:0] t;
        t = {1'b0, len} + 17'd1;
        return t[16:1];
    endfunction

    function automatic logic len_legal(input logic [15:0] len, input int unsigned max_len);
        return (len != 16'd0) && (32'(len) <= max_len);
    endfunction

endpackage

// File: rtl/vpr_ctrl.sv
module vpr_ctrl
    import vpr_pkg::*;
#(
    parameter logic [63:0] SYNC_WORD = 64'hA5C3_5A3C_0FF0_96E1,
    parameter int          MAX_LEN   = 1024,
    localparam int         BW        = $clog2(MAX_LEN / 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_empty,
    input  logic          in_ack,
    input  logic [63:0]   in_data,
    input  logic [15:0]   new_len,
    input  logic [15:0]   cur_len,
    input  logic          grant,
    output logic          in_req,
    output logic          hdr_load,
    output logic          cl_load,
    output logic          pay_en,
    output logic [BW-1:0] beat_idx,
    output logic          last_beat,
    output logic          hdr_valid,
    output logic          pkt_done,
    output logic          sync_err,
    output logic          len_err
);

    vpr_state_t    st, st_n;
    logic [BW-1:0] beat_n;
    logic          done_n, serr_n, lerr_n;
    logic          rd_phase, xfer, is_sync;

    assign rd_phase  = (st == ST_HDR) || (st == ST_PAY) || (st == ST_TAIL) || (st == ST_DISC);
    assign in_req    = rd_phase && !in_empty;
    assign xfer      = in_req && in_ack;
    assign is_sync   = (in_data == SYNC_WORD);
    assign last_beat = (16'(beat_idx) == (beats_of(cur_len) - 16'd1));
    assign hdr_load  = xfer && (st == ST_HDR);
    assign cl_load   = (st == ST_GRANT) && grant;
    assign pay_en    = xfer && (st == ST_PAY);
    assign hdr_valid = (st == ST_GRANT);

    always_comb begin
        st_n   = st;
        beat_n = beat_idx;
        done_n = 1'b0;
        serr_n = 1'b0;
        lerr_n = 1'b0;
        case (st)
            ST_IDLE: if (!in_empty) st_n = ST_HDR;
            ST_HDR: begin
                if (xfer) begin
                    if (len_legal(new_len, MAX_LEN)) begin
                        st_n = ST_GRANT;
                    end else begin
                        st_n   = ST_DISC;
                        lerr_n = 1'b1;
                    end
                end
            end
            ST_GRANT: begin
                beat_n = '0;
                if (grant) st_n = ST_PAY;
            end
            ST_PAY: begin
                if (xfer) begin
                    if (last_beat) begin
                        st_n   = ST_TAIL;
                        beat_n = '0;
                    end else begin
                        beat_n = beat_idx + 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                if (xfer) begin
                    if (is_sync) begin
                        st_n   = ST_IDLE;
                        done_n = 1'b1;
                    end else begin
                        st_n   = ST_DISC;
                        serr_n = 1'b1;
                    end
                end
            end
            ST_DISC: if (xfer && is_sync) st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            beat_idx <= '0;
            pkt_done <= 1'b0;
            sync_err <= 1'b0;
            len_err  <= 1'b0;
        end else begin
            st       <= st_n;
            beat_idx <= beat_n;
            pkt_done <= done_n;
            sync_err <= serr_n;
            len_err  <= lerr_n;
        end
    end

endmodule

// File: rtl/vpr_hdr_latch.sv
module vpr_hdr_latch
    import vpr_pkg::*;
#(
    parameter int  NCL = 4,
    localparam int CLW = $clog2(NCL)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           hdr_load,
    input  vpr_hdr_t       in_hdr,
    input  logic           cl_load,
    input  logic [CLW-1:0] grant_cluster,
    output logic           hdr_type,
    output logic           hdr_ctl,
    output logic [3:0]     hdr_ver,
    output logic [7:0]     hdr_target,
    output logic [15:0]    hdr_len,
    output logic [31:0]    hdr_vid,
    output logic [CLW-1:0] cur_cluster
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_type    <= 1'b0;
            hdr_ctl     <= 1'b0;
            hdr_ver     <= '0;
            hdr_target  <= '0;
            hdr_len     <= '0;
            hdr_vid     <= '0;
            cur_cluster <= '0;
        end else begin
            if (hdr_load) begin
                hdr_type   <= in_hdr.is_cmd;
                hdr_ctl    <= in_hdr.sw_ctl;
                hdr_ver    <= in_hdr.ver;
                hdr_target <= in_hdr.target;
                hdr_len    <= in_hdr.len;
                hdr_vid    <= in_hdr.vid;
            end
            if (cl_load) cur_cluster <= grant_cluster;
        end
    end

endmodule

// File: rtl/vpr_steer.sv
module vpr_steer #(
    parameter int  NCL = 4,
    parameter int  BW  = 9,
    localparam int CLW = $clog2(NCL)
) (
    input  logic           pay_en,
    input  logic [63:0]    in_data,
    input  logic           last_beat,
    input  logic           odd_len,
    input  logic [CLW-1:0] cur_cluster,
    input  logic [BW-1:0]  beat_idx,
    output logic           wr_en,
    output logic [NCL-1:0] wr_cs,
    output logic [63:0]    wr_data,
    output logic [BW-1:0]  wr_cnt,
    output logic           wr_last
);

    for (genvar i = 0; i < NCL; i++) begin : g_cs
        assign wr_cs[i] = pay_en && (cur_cluster == CLW'(i));
    end

    assign wr_en   = pay_en;
    assign wr_last = pay_en && last_beat;
    assign wr_cnt  = beat_idx;
    assign wr_data = {((last_beat && odd_len) ? 32'd0 : in_data[63:32]), in_data[31:0]};

endmodule

// File: rtl/vec_pkt_reader.sv
module vec_pkt_reader
    import vpr_pkg::*;
#(
    parameter int          NCL       = 4,
    parameter int          MAX_LEN   = 1024,
    parameter logic [63:0] SYNC_WORD = 64'hA5C3_5A3C_0FF0_96E1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [63:0]                  in_data,
    input  logic                         in_empty,
    input  logic                         in_ack,
    output logic                         in_req,
    output logic                         hdr_valid,
    output logic                         hdr_type,
    output logic                         hdr_ctl,
    output logic [3:0]                   hdr_ver,
    output logic [7:0]                   hdr_target,
    output logic [15:0]                  hdr_len,
    output logic [31:0]                  hdr_vid,
    input  logic                         grant,
    input  logic [$clog2(NCL)-1:0]       grant_cluster,
    output logic                         wr_en,
    output logic [NCL-1:0]               wr_cs,
    output logic [63:0]                  wr_data,
    output logic [$clog2(MAX_LEN/2)-1:0] wr_cnt,
    output logic                         wr_last,
    output logic                         pkt_done,
    output logic                         sync_err,
    output logic                         len_err
);

    localparam int CLW = $clog2(NCL);
    localparam int BW  = $clog2(MAX_LEN / 2);

    vpr_hdr_t       in_hdr;
    logic           hdr_load, cl_load, pay_en, last_beat;
    logic [BW-1:0]  beat_idx;
    logic [CLW-1:0] cur_cluster;

    assign in_hdr = vpr_hdr_t'(in_data[61:0]);

    vpr_ctrl #(.SYNC_WORD(SYNC_WORD), .MAX_LEN(MAX_LEN)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .in_empty  (in_empty),
        .in_ack    (in_ack),
        .in_data   (in_data),
        .new_len   (in_hdr.len),
        .cur_len   (hdr_len),
        .grant     (grant),
        .in_req    (in_req),
        .hdr_load  (hdr_load),
        .cl_load   (cl_load),
        .pay_en    (pay_en),
        .beat_idx  (beat_idx),
        .last_beat (last_beat),
        .hdr_valid (hdr_valid),
        .pkt_done  (pkt_done),
        .sync_err  (sync_err),
        .len_err   (len_err)
    );

    vpr_hdr_latch #(.NCL(NCL)) hdr_i (
        .clk           (clk),
        .rst           (rst),
        .hdr_load      (hdr_load),
        .in_hdr        (in_hdr),
        .cl_load       (cl_load),
        .grant_cluster (grant_cluster),
        .hdr_type      (hdr_type),
        .hdr_ctl       (hdr_ctl),
        .hdr_ver       (hdr_ver),
        .hdr_target    (hdr_target),
        .hdr_len       (hdr_len),
        .hdr_vid       (hdr_vid),
        .cur_cluster   (cur_cluster)
    );

    vpr_steer #(.NCL(NCL), .BW(BW)) steer_i (
        .pay_en      (pay_en),
        .in_data     (in_data),
        .last_beat   (last_beat),
        .odd_len     (hdr_len[0]),
        .cur_cluster (cur_cluster),
        .beat_idx    (beat_idx),
        .wr_en       (wr_en),
        .wr_cs       (wr_cs),
        .wr_data     (wr_data),
        .wr_cnt      (wr_cnt),
        .wr_last     (wr_last)
    );

endmodule

// File: rtl/vpr_checker.sv
module vpr_checker #(
    parameter int NCL = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           in_empty,
    input logic           in_ack,
    input logic           in_req,
    input logic           hdr_valid,
    input logic [15:0]    hdr_len,
    input logic [31:0]    hdr_vid,
    input logic           grant,
    input logic           wr_en,
    input logic [NCL-1:0] wr_cs,
    input logic [63:0]    wr_data,
    input logic           wr_last,
    input logic           pkt_done,
    input logic           sync_err,
    input logic           len_err
);

    p_req_gated_r1: assert property (@(posedge clk) disable iff (rst)
        in_empty |-> !in_req);

    p_hold_hdr_r3: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && !grant) |=> (hdr_valid && $stable(hdr_vid) && $stable(hdr_len)));

    p_no_read_wait_r3: assert property (@(posedge clk) disable iff (rst)
        hdr_valid |-> !in_req);

    p_len_err_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        len_err |=> !len_err);

    p_cs_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ($countones(wr_cs) == 1));

    p_cs_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> (wr_cs == '0));

    p_pad_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_last && hdr_len[0]) |-> (wr_data[63:32] == 32'd0));

    p_flag_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(sync_err && pkt_done));

    p_sync_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        sync_err |=> !sync_err);

    p_write_on_xfer_r9: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (in_req && in_ack));

endmodule

bind vec_pkt_reader vpr_checker #(.NCL(NCL)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_empty  (in_empty),
    .in_ack    (in_ack),
    .in_req    (in_req),
    .hdr_valid (hdr_valid),
    .hdr_len   (hdr_len),
    .hdr_vid   (hdr_vid),
    .grant     (grant),
    .wr_en     (wr_en),
    .wr_cs     (wr_cs),
    .wr_data   (wr_data),
    .wr_last   (wr_last),
    .pkt_done  (pkt_done),
    .sync_err  (sync_err),
    .len_err   (len_err)
);

// File: tb/vec_pkt_reader_tb_top.sv
module vec_pkt_reader_tb_top;

    localparam int          NCL  = 4;
    localparam int          MAXL = 1024;
    localparam logic [63:0] SYNC = 64'hA5C3_5A3C_0FF0_96E1;
    localparam int          BW   = $clog2(MAXL / 2);

    typedef struct {
        logic [63:0] data;
        int          cs;
        int          cnt;
        bit          last;
    } beat_t;

    typedef struct {
        bit          typ;
        bit          ctl;
        logic [3:0]  ver;
        logic [7:0]  tgt;
        logic [15:0] len;
        logic [31:0] vid;
        int          cl;
    } hdr_exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [63:0] in_data = '0;
    logic in_empty = 1'b1;
    logic in_ack = 1'b0;
    logic in_req, hdr_valid, hdr_type, hdr_ctl;
    logic [3:0] hdr_ver;
    logic [7:0] hdr_target;
    logic [15:0] hdr_len;
    logic [31:0] hdr_vid;
    logic grant = 1'b0;
    logic [1:0] grant_cluster = '0;
    logic wr_en, wr_last, pkt_done, sync_err, len_err;
    logic [NCL-1:0] wr_cs;
    logic [63:0] wr_data;
    logic [BW-1:0] wr_cnt;

    int tests = 0, fails = 0, cyc = 0;
    int r1_viol = 0, r3_viol = 0;
    bit ack_full = 1'b1;
    bit take = 1'b0;
    bit done_flag = 1'b0;
    int gdelay = 0;

    logic [63:0] fifo_q[$];
    beat_t       exp_beats[$];
    hdr_exp_t    exp_hdr[$];
    int          exp_evt[$];   // 0 done, 1 sync error, 2 length error

    always #5 clk = ~clk;

    vec_pkt_reader #(.NCL(NCL), .MAX_LEN(MAXL), .SYNC_WORD(SYNC)) dut_i (
        .clk(clk), .rst(rst), .in_data(in_data), .in_empty(in_empty), .in_ack(in_ack),
        .in_req(in_req), .hdr_valid(hdr_valid), .hdr_type(hdr_type), .hdr_ctl(hdr_ctl),
        .hdr_ver(hdr_ver), .hdr_target(hdr_target), .hdr_len(hdr_len), .hdr_vid(hdr_vid),
        .grant(grant), .grant_cluster(grant_cluster), .wr_en(wr_en), .wr_cs(wr_cs),
        .wr_data(wr_data), .wr_cnt(wr_cnt), .wr_last(wr_last), .pkt_done(pkt_done),
        .sync_err(sync_err), .len_err(len_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // FIFO model: pop on an accepted handshake, update head after the edge.
    initial begin
        forever begin
            @(posedge clk);
            if (take) void'(fifo_q.pop_front());
            #1;
            cyc++;
            in_ack   = ack_full ? 1'b1 : ((cyc % 3) != 0);
            in_empty = (fifo_q.size() == 0);
            in_data  = (fifo_q.size() == 0) ? 64'd0 : fifo_q[0];
        end
    end

    // Monitor at the falling edge.
    always @(negedge clk) begin
        take = in_req && in_ack;
        if (!rst) begin
            if (in_empty && in_req) r1_viol++;
            if (hdr_valid && in_req) r3_viol++;
            if (wr_en) begin
                if (exp_beats.size() == 0) begin
                    check(1'b0, "R8", "unexpected write", wr_data, 64'd0);
                end else begin
                    beat_t e;
                    e = exp_beats.pop_front();
                    check(wr_data == e.data, "R5", "beat data", wr_data, e.data);
                    check(wr_cs == NCL'(1 << e.cs), "R5", "cluster select", 64'(wr_cs), 64'(1 << e.cs));
                    check(int'(wr_cnt) == e.cnt, "R9", "beat index", 64'(wr_cnt), 64'(e.cnt));
                    check(wr_last == e.last, "R6", "last flag", 64'(wr_last), 64'(e.last));
                end
            end
            if (pkt_done || sync_err || len_err) begin
                int code;
                code = pkt_done ? 0 : (sync_err ? 1 : 2);
                if (exp_evt.size() == 0) begin
                    check(1'b0, "R7", "unexpected event", 64'(code), 64'hFF);
                end else begin
                    int e;
                    e = exp_evt.pop_front();
                    check(code == e, (e == 0) ? "R7" : ((e == 1) ? "R8" : "R4"),
                          "event code", 64'(code), 64'(e));
                end
            end
        end
    end

    // Main controller model: checks the header, then grants after a delay.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && hdr_valid) begin
                hdr_exp_t h;
                if (exp_hdr.size() == 0) begin
                    check(1'b0, "R4", "unexpected header", 64'(hdr_len), 64'd0);
                    h.cl = 0;
                end else begin
                    h = exp_hdr.pop_front();
                    check({hdr_type, hdr_ctl, hdr_ver, hdr_target} == {h.typ, h.ctl, h.ver, h.tgt},
                          "R2", "header control bits", 64'({hdr_type, hdr_ctl, hdr_ver, hdr_target}),
                          64'({h.typ, h.ctl, h.ver, h.tgt}));
                    check({hdr_len, hdr_vid} == {h.len, h.vid}, "R2", "header len/id",
                          {16'd0, hdr_len, hdr_vid}, {16'd0, h.len, h.vid});
                end
                repeat (gdelay) @(posedge clk);
                #1;
                grant = 1'b1;
                grant_cluster = 2'(h.cl);
                gdelay = (gdelay + 1) % 4;
                @(posedge clk);
                #1;
                grant = 1'b0;
                grant_cluster = 2'(h.cl + 1);
            end
        end
    end

    function automatic logic [31:0] elem(input logic [31:0] vid, input int i);
        return {vid[15:0], 16'(i)};
    endfunction

    task automatic send_pkt(input bit typ, input bit ctl, input logic [3:0] ver,
                            input logic [7:0] tgt, input int len, input logic [31:0] vid,
                            input int cl, input bit good_tail, input logic [1:0] top);
        logic [63:0] hw;
        hw = {top, typ, ctl, ver, tgt, 16'(len), vid};
        fifo_q.push_back(hw);
        if (len == 0 || len > MAXL) begin
            exp_evt.push_back(2);
            return;
        end
        exp_hdr.push_back('{typ, ctl, ver, tgt, 16'(len), vid, cl});
        for (int b = 0; b < (len + 1) / 2; b++) begin
            logic [31:0] lo, hi_f, hi_e;
            beat_t e;
            lo   = elem(vid, 2 * b);
            hi_f = (2 * b + 1 < len) ? elem(vid, 2 * b + 1) : 32'hDEAD_BEEF;
            hi_e = (2 * b + 1 < len) ? elem(vid, 2 * b + 1) : 32'd0;
            fifo_q.push_back({hi_f, lo});
            e.data = {hi_e, lo};
            e.cs   = cl;
            e.cnt  = b;
            e.last = (b == (len + 1) / 2 - 1);
            exp_beats.push_back(e);
        end
        fifo_q.push_back(good_tail ? SYNC : (SYNC ^ 64'h1));
        exp_evt.push_back(good_tail ? 0 : 1);
    endtask

    task automatic drain();
        while (fifo_q.size() != 0 || exp_beats.size() != 0 || exp_evt.size() != 0) @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        check({in_req, hdr_valid, wr_en, pkt_done, sync_err, len_err} == 6'd0 && wr_cs == '0,
              "R10", "outputs in reset", 64'({in_req, hdr_valid, wr_en, wr_cs, pkt_done, sync_err, len_err}), 64'd0);
        @(posedge clk);
        #2;
        rst = 1'b0;

        // Even length, full-rate acknowledge
        send_pkt(1'b0, 1'b1, 4'h3, 8'h11, 8, 32'h0000_1A2B, 1, 1'b1, 2'b00);
        drain();
        // Odd length with stalls; ignored top header bits set (R2)
        ack_full = 1'b0;
        send_pkt(1'b1, 1'b0, 4'hC, 8'h7E, 5, 32'hCAFE_0005, 2, 1'b1, 2'b11);
        drain();
        // Single element (R6 padding on first and only beat)
        send_pkt(1'b0, 1'b0, 4'h1, 8'h02, 1, 32'h0BAD_0001, 0, 1'b1, 2'b00);
        drain();
        // Bad tail, junk words, resync, then a good packet (R8)
        send_pkt(1'b1, 1'b1, 4'h9, 8'hA0, 4, 32'h1234_0004, 3, 1'b0, 2'b00);
        fifo_q.push_back(64'h1111_2222_3333_4444);
        fifo_q.push_back(SYNC ^ 64'h8000_0000_0000_0000);
        fifo_q.push_back(SYNC);
        send_pkt(1'b0, 1'b1, 4'h2, 8'h33, 3, 32'h5555_0003, 3, 1'b1, 2'b00);
        drain();
        // Zero length header (R4), discard until sync, then next packet
        send_pkt(1'b0, 1'b0, 4'h0, 8'h00, 0, 32'h0, 0, 1'b1, 2'b00);
        fifo_q.push_back(64'h0000_0002_0000_0002);
        fifo_q.push_back(SYNC);
        send_pkt(1'b1, 1'b0, 4'h5, 8'h44, 2, 32'h7777_0002, 1, 1'b1, 2'b00);
        drain();
        // Over-long header (R4)
        ack_full = 1'b1;
        send_pkt(1'b0, 1'b0, 4'h0, 8'h00, MAXL + 1, 32'h0, 0, 1'b1, 2'b00);
        fifo_q.push_back(SYNC);
        drain();
        // Maximum length with stalls (R5, R9)
        ack_full = 1'b0;
        send_pkt(1'b0, 1'b1, 4'hF, 8'hFF, MAXL, 32'h9ABC_0400, 2, 1'b1, 2'b00);
        drain();

        check(r1_viol == 0, "R1", "requests while empty", 64'(r1_viol), 64'd0);
        check(r3_viol == 0, "R3", "reads while waiting for grant", 64'(r3_viol), 64'd0);
        check(exp_hdr.size() == 0, "R3", "headers left", 64'(exp_hdr.size()), 64'd0);
        check(exp_beats.size() == 0, "R9", "beats left", 64'(exp_beats.size()), 64'd0);
        done_flag = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule